// File: doc/BRIEF.md
# Per-Core Compare-Value Timer

This block is the deadline timer attached to one processor core. A shared 64-bit system count, produced elsewhere and free-running, arrives as an input. Software programs a 64-bit limit, and once the count reaches that limit a status flag latches. A level interrupt goes to the core's private interrupt line while that flag is set, the timer is enabled and the interrupt is not masked.

The limit can be programmed in two ways. The absolute view writes the 64-bit limit directly. The relative view adds a signed 32-bit distance to the current count. Reading the relative view gives the low 32 bits of the remaining distance. A 3-bit control word holds the enable and mask bits, which software can write, and the latched status flag, which it can only read.

Register access is a small synchronous port with a 2-bit view select, a write strobe and 64-bit data. Read data follows the select and the present state in the same cycle.

Top module: `cmp_timer_core`

## Requirements
- R1: While reset is held, at the clock edge the limit, the control bits, the status flag and the interrupt all clear to zero. Reset is synchronous and active high.
- R2: The status flag is set one clock edge after a cycle in which the count is greater than or equal to the limit. The comparison is unsigned.
- R3: Once set, the status flag stays set whatever the enable and mask bits are, including while the timer is disabled. Only a write to the limit through view 0 or view 1 can clear it.
- R4: The interrupt output is registered. After each clock edge it equals status AND enable AND NOT mask, so it changes in the same cycle as the status flag.
- R5: A write with select 0 loads the full 64-bit write data as the limit. At that edge the status flag becomes (count >= new limit), so it clears at once if the new limit is above the count.
- R6: A write with select 1 loads the limit with the count plus the low 32 bits of the write data sign-extended to 64 bits, using modulo 2^64 arithmetic. Bits 63:32 of the write data are ignored. The status flag is re-evaluated as in R5.
- R7: A read with select 1 returns the low 32 bits of (limit minus count) in bits 31:0, with bits 63:32 zero.
- R8: A write with select 2 updates enable from bit 0 and mask from bit 1. Bit 2, the status flag, and all higher bits of the write data are ignored.
- R9: Read encoding. Select 0 returns the limit. Select 2 returns enable in bit 0, mask in bit 1 and status in bit 2, with all other bits zero. Select 3 returns zero, and a write with select 3 has no effect.
- R10: Read data is combinational. It reflects the present select, count and state in the same cycle, with no added delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_count | input | 64 | Shared free-running system count |
| reg_sel | input | 2 | View select: 0 limit, 1 relative, 2 control, 3 none |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the selected view |
| irq | output | 1 | Level interrupt to the core |

## Verification
The hardest case to reach from the ports is a relative write whose sum wraps past 2^64. The sum then lands numerically below a count close to the top of the range, so the timer must fire at once rather than schedule a far deadline. The stimulus drives the count input straight to values a few steps short of the maximum and then writes small positive distances. It also writes negative distances from ordinary counts, which puts the limit behind the count. A long stretch with random selects, data and count jumps is then compared on every clock against a behavioural model.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;

    parameter int CNT_W   = 64;
    parameter int DELTA_W = 32;

    typedef enum logic [1:0] {
        SEL_LIMIT = 2'd0,
        SEL_DELTA = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } view_e;

    // bit 0 run, bit 1 mask, bit 2 fired
    typedef struct packed {
        logic fired;
        logic mask;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic reached(input logic [CNT_W-1:0] count,
                                     input logic [CNT_W-1:0] limit);
        return count >= limit;
    endfunction

endpackage

// File: rtl/cmpt_limit.sv
module cmpt_limit
    import cmpt_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int DW = DELTA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  view_e        sel,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] count,
    output logic         load,
    output logic [W-1:0] limit_next,
    output logic [W-1:0] limit_q
);
    localparam int EXT_W = W - DW;

    logic [W-1:0] delta_ext;
    logic [W-1:0] load_val;

    always_comb begin
        delta_ext  = {{EXT_W{wdata[DW-1]}}, wdata[DW-1:0]};
        load       = wr && (sel == SEL_LIMIT || sel == SEL_DELTA);
        load_val   = (sel == SEL_DELTA) ? count + delta_ext : wdata;
        limit_next = load ? load_val : limit_q;
    end

    always_ff @(posedge clk) begin
        if (rst)       limit_q <= '0;
        else if (load) limit_q <= load_val;
    end

    assert_limit_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(limit_q));

endmodule

// File: rtl/cmpt_state.sv
module cmpt_state
    import cmpt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctl_wr,
    input  logic [1:0]   ctl_bits,
    input  logic         load,
    input  logic [W-1:0] limit_next,
    input  logic [W-1:0] count,
    output ctrl_t        ctrl_q,
    output logic         irq
);
    ctrl_t ctrl_d;
    logic  hit;

    always_comb begin
        hit    = reached(count, limit_next);
        ctrl_d = ctrl_q;
        if (ctl_wr) begin
            ctrl_d.run  = ctl_bits[0];
            ctrl_d.mask = ctl_bits[1];
        end
        // a new limit re-evaluates from scratch; otherwise the flag is sticky
        ctrl_d.fired = hit | (ctrl_q.fired & ~load);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            irq    <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            irq    <= ctrl_d.fired & ctrl_d.run & ~ctrl_d.mask;
        end
    end

    assert_fired_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.fired && !load |=> ctrl_q.fired);

    assert_irq_gated_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl_q.run && !ctrl_q.mask && ctrl_q.fired));

    assert_reeval_clear_R5: assert property (@(posedge clk) disable iff (rst)
        load && (count < limit_next) |=> !ctrl_q.fired);

    assert_reach_sets_R2: assert property (@(posedge clk) disable iff (rst)
        !load && reached(count, limit_next) |=> ctrl_q.fired);

endmodule

// File: rtl/cmpt_readout.sv
module cmpt_readout
    import cmpt_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int DW = DELTA_W
) (
    input  view_e        sel,
    input  logic [W-1:0] limit_q,
    input  logic [W-1:0] count,
    input  ctrl_t        ctrl_q,
    output logic [W-1:0] rdata
);
    logic [W-1:0] remain;

    always_comb begin
        remain = limit_q - count;
        unique case (sel)
            SEL_LIMIT: rdata = limit_q;
            SEL_DELTA: rdata = {{(W-DW){1'b0}}, remain[DW-1:0]};
            SEL_CTRL:  rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core
    import cmpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] sys_count,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq
);
    view_e            sel;
    logic             load;
    logic [CNT_W-1:0] limit_next;
    logic [CNT_W-1:0] limit_q;
    ctrl_t            ctrl_q;
    logic             ctl_wr;

    assign sel    = view_e'(reg_sel);
    assign ctl_wr = reg_wr && (sel == SEL_CTRL);

    cmpt_limit #(.W(CNT_W), .DW(DELTA_W)) u_limit (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .sel        (sel),
        .wdata      (reg_wdata),
        .count      (sys_count),
        .load       (load),
        .limit_next (limit_next),
        .limit_q    (limit_q)
    );

    cmpt_state #(.W(CNT_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .ctl_bits   (reg_wdata[1:0]),
        .load       (load),
        .limit_next (limit_next),
        .count      (sys_count),
        .ctrl_q     (ctrl_q),
        .irq        (irq)
    );

    cmpt_readout #(.W(CNT_W), .DW(DELTA_W)) u_read (
        .sel     (sel),
        .limit_q (limit_q),
        .count   (sys_count),
        .ctrl_q  (ctrl_q),
        .rdata   (reg_rdata)
    );

    assert_none_write_R9: assert property (@(posedge clk) disable iff (rst)
        reg_wr && sel == SEL_NONE |=> $stable(limit_q) && $stable(ctrl_q.run) && $stable(ctrl_q.mask));

endmodule

// File: tb/cmp_timer_core_tb.sv
module cmp_timer_core_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] cnt = 64'd5;
    logic [1:0]  sel = 2'd0;
    logic        wr  = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // behavioural reference state
    logic [63:0] m_lim = '0;
    logic        m_en = 1'b0, m_msk = 1'b0, m_st = 1'b0, m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer_core u_dut (
        .clk(clk), .rst(rst), .sys_count(cnt), .reg_sel(sel),
        .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_lim = '0; m_en = 0; m_msk = 0; m_st = 0;
        end else if (wr && sel == 2'd0) begin
            m_lim = wdata;
            m_st  = (cnt >= m_lim);
        end else if (wr && sel == 2'd1) begin
            m_lim = cnt + {{32{wdata[31]}}, wdata[31:0]};
            m_st  = (cnt >= m_lim);
        end else begin
            if (wr && sel == 2'd2) begin
                m_en  = wdata[0];
                m_msk = wdata[1];
            end
            if (cnt >= m_lim) m_st = 1'b1;
        end
        m_irq = m_st & m_en & ~m_msk;
    end

    function automatic logic [63:0] model_read(input logic [1:0] s);
        logic [63:0] diff;
        diff = m_lim - cnt;
        case (s)
            2'd0:    return m_lim;
            2'd1:    return {32'd0, diff[31:0]};
            2'd2:    return {61'd0, m_st, m_msk, m_en};
            default: return 64'd0;
        endcase
    endfunction

    task automatic check_all();
        logic [1:0] keep;
        string tag;
        keep = sel;
        for (int k = 0; k < 4; k++) begin
            sel = 2'(k);
            #1;
            case (k)
                0: tag = rst ? "R1" : "R5 R6 R10";
                1: tag = "R7 R10";
                2: tag = rst ? "R1" : "R2 R3 R8 R9";
                default: tag = "R9";
            endcase
            checks++;
            if (rdata !== model_read(2'(k))) begin
                errors++;
                $display("FAIL %s view %0d: got %h expected %h", tag, k, rdata, model_read(2'(k)));
            end
        end
        sel = keep;
        checks++;
        if (irq !== m_irq) begin
            errors++;
            $display("FAIL %s irq: got %b expected %b", rst ? "R1" : "R4", irq, m_irq);
        end
    endtask

    // one cycle: check present state, then drive next inputs
    task automatic tick(input logic w, input logic [1:0] s, input logic [63:0] d,
                        input logic [63:0] c);
        @(negedge clk);
        check_all();
        rst = 1'b0; wr = w; sel = s; wdata = d; cnt = c;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 2'd0, 64'd0, cnt + 64'd1);
    endtask

    initial begin
        @(posedge clk); @(posedge clk);
        // R1: reset state observed while reset held
        @(negedge clk); check_all();
        @(negedge clk); check_all();
        tick(1'b0, 2'd0, 64'd0, 64'd6);
        run(3);                                             // R2: limit 0 reached at once
        tick(1'b1, 2'd2, 64'h7, cnt + 1);                   // R8: bit 2 ignored
        tick(1'b1, 2'd0, cnt + 64'd20, cnt + 1);            // R5: clear
        tick(1'b1, 2'd2, 64'h1, cnt + 1);                   // enable, unmask
        run(25);                                            // R2 R4 fire
        tick(1'b1, 2'd2, 64'h3, cnt + 1);                   // R4 mask drops irq, R3 keeps status
        run(2);
        tick(1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFF9, cnt + 1); // R8 upper bits ignored
        tick(1'b1, 2'd1, 64'd100, cnt + 1);                 // R6 relative, clears
        run(4);
        tick(1'b1, 2'd1, 64'h0000_0000_FFFF_FFFB, cnt + 1); // R6 negative, immediate fire
        run(2);
        tick(1'b1, 2'd2, 64'h0, cnt + 1);                   // disable
        tick(1'b1, 2'd0, cnt + 64'd3, cnt + 1);
        run(6);                                             // R3 fires while disabled
        tick(1'b1, 2'd3, 64'hFFFF, cnt + 1);                // R9 no effect
        run(2);
        tick(1'b1, 2'd2, 64'h1, 64'hFFFF_FFFF_FFFF_FFF0);
        tick(1'b1, 2'd1, 64'h20, cnt + 1);                  // R6 wraps past 2^64
        run(3);
        tick(1'b1, 2'd1, 64'hDEAD_BEEF_0000_0040, cnt + 1); // R6 upper bits ignored
        run(3);
        for (int i = 0; i < 400; i++) begin
            logic [63:0] rd, nc;
            rd = {$urandom, $urandom};
            if ($urandom_range(0, 1) == 0) rd = cnt + 64'($urandom_range(0, 40));
            nc = ($urandom_range(0, 15) == 0) ? {$urandom, $urandom} : cnt + 64'($urandom_range(0, 3));
            tick($urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)), rd, nc);
        end
        tick(1'b0, 2'd0, 64'd0, cnt);
        tick(1'b0, 2'd0, 64'd0, cnt);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule